// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the running address for a four-beat memory burst. A start pulse captures a full external address. That address is the first beat. From then on, each cycle with the active-low step input low moves the two low-order bits to the next beat. The upper bits stay as they were captured. A cycle with step high holds the current address, which gives the burst a wait state.

Two beat orders are offered. The order is chosen by an order-select pin, which is sampled on the start cycle. With the pin high, the order is interleaved: the low bits are the captured low bits XOR a beat count. With the pin low, the order is linear: the low bits are the captured low bits plus the beat count, wrapping modulo four. Stepping past the fourth beat wraps back to the first.

The output is registered and changes one clock edge after the cycle that caused the change. Reset is synchronous and active high.

Top module: `burst_addr_seq`

## Requirements
- R1: One edge after a cycle with `start` high, `addr_q` equals the `ext_addr` that was sampled in that cycle.
- R2: When `order_sel` was 1 at start, each step gives low bits equal to the start low bits XOR the beat count 0,1,2,3. For example, start 01 gives 01,00,11,10, and start 11 gives 11,10,01,00.
- R3: When `order_sel` was 0 at start, each step gives low bits equal to the start low bits plus the beat count, modulo 4. For example, start 10 gives 10,11,00,01, and start 11 gives 11,00,01,10.
- R4: A cycle with `start` low and `step_n` low moves `addr_q` to the next beat one edge later.
- R5: A cycle with `start` low and `step_n` high leaves `addr_q` unchanged.
- R6: A step taken from the fourth beat returns the low bits to the start low bits, and the sequence then repeats.
- R7: Bits above bit 1 of `addr_q` keep their captured value throughout a burst. `ext_addr` has no effect when `start` is low.
- R8: When `start` and a step (`step_n` low) fall in the same cycle, the start wins. The next `addr_q` is `ext_addr` at beat 0.
- R9: With `rst` high, `addr_q` becomes 0 at the next edge. The beat count also returns to 0, and the order becomes interleaved. A step after reset therefore gives address 1.
- R10: A change of `order_sel` while `start` is low has no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture `ext_addr` and begin a burst |
| ext_addr | input | ADDR_W | External first-beat address |
| step_n | input | 1 | Advance to next beat, active low |
| order_sel | input | 1 | 1 = interleaved, 0 = linear; sampled on start |
| addr_q | output | ADDR_W | Current burst address, registered |

## Verification
Start and step can both be asserted in the same cycle. If they are, the start must win, and the beat count restarts at zero.

The vector table contains a vector with both inputs active. The expected address for that vector is the fresh external address. That vector is followed by steps, so a counter that was not cleared would show up as a wrong low-bit sequence. Reset is also applied in the middle of a burst, so that a surviving count would be caught by the first step after release.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              adv,
  output logic [BEAT_W-1:0] cnt_q,
  output logic [BEAT_W-1:0] cnt_d
);
  always_comb begin
    if (clear)    cnt_d = '0;
    else if (adv) cnt_d = cnt_q + 1'b1;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R4: a step with no clear moves the count by exactly one
  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    (!clear && adv) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R5: no step, no clear keeps the count
  a_r5_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!clear && !adv) |=> $stable(cnt_q));
endmodule

// File: rtl/burst_lowbits.sv
module burst_lowbits
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  order_e            order,
  input  logic [BEAT_W-1:0] base_lo,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] lo
);
  logic [BEAT_W-1:0] lo_xor;
  logic [BEAT_W-1:0] lo_add;

  assign lo_xor = base_lo ^ beat;
  assign lo_add = base_lo + beat;

  always_comb begin
    if (order == ORD_INTERLEAVE) lo = lo_xor;
    else                         lo = lo_add;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              step_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [HI_W-1:0]   base_hi_q, base_hi_d;
  logic [BEAT_W-1:0] base_lo_q, base_lo_d;
  order_e            order_q, order_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [BEAT_W-1:0] lo_d;

  burst_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (start),
    .adv   (!step_n),
    .cnt_q (beat_q),
    .cnt_d (beat_d)
  );

  always_comb begin
    if (start) begin
      base_hi_d = ext_addr[ADDR_W-1:BEAT_W];
      base_lo_d = ext_addr[BEAT_W-1:0];
      order_d   = order_e'(order_sel);
    end else begin
      base_hi_d = base_hi_q;
      base_lo_d = base_lo_q;
      order_d   = order_q;
    end
  end

  burst_lowbits #(.BEAT_W(BEAT_W)) u_lo (
    .order   (order_d),
    .base_lo (base_lo_d),
    .beat    (beat_d),
    .lo      (lo_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi_q <= '0;
      base_lo_q <= '0;
      order_q   <= ORD_INTERLEAVE;
      addr_q    <= '0;
    end else begin
      base_hi_q <= base_hi_d;
      base_lo_q <= base_lo_d;
      order_q   <= order_d;
      addr_q    <= {base_hi_d, lo_d};
    end
  end

  // R1 / R8: start captures the external address, step or not
  a_r1_capture: assert property (@(posedge clk) disable iff (rst)
    start |=> (addr_q == $past(ext_addr)));

  // R5: hold cycle keeps the output address
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!start && step_n) |=> $stable(addr_q));

  // R7: upper bits stay put without a start
  a_r7_upper: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(addr_q[ADDR_W-1:BEAT_W]));

  // R4: a step always changes the low bits
  a_r4_moves: assert property (@(posedge clk) disable iff (rst)
    (!start && !step_n) |=> (addr_q[BEAT_W-1:0] != $past(addr_q[BEAT_W-1:0])));

  // R9: reset clears the address
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (addr_q == '0));
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int AW = 17;
  localparam int NV = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          step_n = 1'b1;
  logic          order_sel = 1'b1;
  logic [AW-1:0] addr_q;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) dut (
    .clk(clk), .rst(rst), .start(start), .ext_addr(ext_addr),
    .step_n(step_n), .order_sel(order_sel), .addr_q(addr_q)
  );

  // fields: req(4) start(1) step_n(1) order_sel(1) ext_addr(17) expected(17)
  localparam logic [40:0] VEC [NV] = '{
    {4'd1,  1'b1, 1'b1, 1'b1, 17'h048D1, 17'h048D1}, // R1 capture, interleaved
    {4'd2,  1'b0, 1'b0, 1'b1, 17'h1FFFF, 17'h048D0}, // R2 01->00, R7 ext ignored
    {4'd2,  1'b0, 1'b0, 1'b1, 17'h00000, 17'h048D3}, // R2 ->11
    {4'd5,  1'b0, 1'b1, 1'b1, 17'h00000, 17'h048D3}, // R5 wait
    {4'd2,  1'b0, 1'b0, 1'b1, 17'h00000, 17'h048D2}, // R2 ->10
    {4'd6,  1'b0, 1'b0, 1'b1, 17'h00000, 17'h048D1}, // R6 wrap to start
    {4'd1,  1'b1, 1'b1, 1'b0, 17'h1FFFE, 17'h1FFFE}, // R1 capture, linear
    {4'd3,  1'b0, 1'b0, 1'b0, 17'h00000, 17'h1FFFF}, // R3 10->11
    {4'd7,  1'b0, 1'b0, 1'b0, 17'h00001, 17'h1FFFC}, // R7 upper kept, 11->00
    {4'd10, 1'b0, 1'b0, 1'b1, 17'h00000, 17'h1FFFD}, // R10 mode change ignored
    {4'd6,  1'b0, 1'b0, 1'b0, 17'h00000, 17'h1FFFE}, // R6 linear wrap
    {4'd8,  1'b1, 1'b0, 1'b0, 17'h00003, 17'h00003}, // R8 start beats step
    {4'd3,  1'b0, 1'b0, 1'b0, 17'h00000, 17'h00000}, // R3 11->00
    {4'd3,  1'b0, 1'b0, 1'b0, 17'h00000, 17'h00001}, // R3 ->01
    {4'd1,  1'b1, 1'b1, 1'b1, 17'h0A5A7, 17'h0A5A7}, // R1 interleaved from 11
    {4'd2,  1'b0, 1'b0, 1'b1, 17'h00000, 17'h0A5A6}, // R2 ->10
    {4'd5,  1'b0, 1'b1, 1'b0, 17'h00000, 17'h0A5A6}, // R5 wait, R10
    {4'd2,  1'b0, 1'b0, 1'b0, 17'h00000, 17'h0A5A5}, // R2 ->01
    {4'd4,  1'b0, 1'b0, 1'b1, 17'h00000, 17'h0A5A4}  // R4 ->00
  };

  task automatic check(input string req, input logic [AW-1:0] exp);
    total++;
    if (addr_q !== exp) begin
      bad++;
      $display("FAIL %s: addr_q=%h expected=%h", req, addr_q, exp);
    end
  endtask

  task automatic cycle(input logic s, input logic sn, input logic m, input logic [AW-1:0] a);
    start = s; step_n = sn; order_sel = m; ext_addr = a;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", '0);
    rst = 1'b0;
    cycle(1'b0, 1'b0, 1'b0, '0);
    check("R9", 17'h00001);
    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i][36], VEC[i][35], VEC[i][34], VEC[i][33:17]);
      check($sformatf("R%0d", VEC[i][40:37]), VEC[i][16:0]);
    end
    // R9: reset in mid-burst, then a step from zero
    cycle(1'b1, 1'b1, 1'b0, 17'h13332);
    cycle(1'b0, 1'b0, 1'b0, '0);
    check("R3", 17'h13333);
    rst = 1'b1;
    cycle(1'b0, 1'b1, 1'b0, '0);
    check("R9", '0);
    rst = 1'b0;
    cycle(1'b0, 1'b0, 1'b0, '0);
    check("R9", 17'h00001);
    cycle(1'b0, 1'b0, 1'b0, '0);
    check("R9", 17'h00002);
    // R8: start and step together in interleaved mode from 10
    cycle(1'b1, 1'b0, 1'b1, 17'h00F0E);
    check("R8", 17'h00F0E);
    cycle(1'b0, 1'b0, 1'b0, '0);
    check("R2", 17'h00F0F);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule